// File: doc/BRIEF.md
# ECAM Configuration Request Translator

This block sits behind a memory-mapped slave port of a PCI Express root-complex bridge. A single-beat read or write that lands inside a fixed address window becomes one configuration request descriptor. The offset within the window supplies the target bus, device and function, the extended and base register numbers, and the byte enables. The descriptor goes to a downstream packet builder through a valid/ready handshake. The block then waits for that request's completion, or for a programmable timeout, before it answers the slave port with a one-cycle response.

Accesses are refused with an error response, and no descriptor is sent, in three cases: the bus-master enable input is low, the access is a burst, or the address falls outside the window. A configuration write is non-posted. When its completion returns unsupported-request status, or when it times out, the block sets a sticky interrupt flag. Each flag is cleared by a write-one-to-clear pulse. Only one request is ever outstanding.

The controller is a four-state machine:
- ST_IDLE accepts an access. It goes to ST_RESP on a refused access and to ST_ISSUE otherwise.
- ST_ISSUE holds the descriptor valid until it is taken, then goes to ST_WAIT.
- ST_WAIT leaves for ST_RESP on a completion or on timeout expiry.
- ST_RESP drives the response for one cycle and returns to ST_IDLE.

Top module: `ecam_cfg_xlate`

## Requirements
- R1: The bus-number width n is log2(HIGH_ADDR-BASE_ADDR+1) minus 20 and must be 1 to 8. The bus number is taken from address bits [19+n:20] and zero-extended to 8 bits on `cfg_bus`. With the defaults (window 0x4000_0000 to 0x40FF_FFFF), n is 4.
- R2: An accepted access in the window issues one descriptor with the following fields:
  - device from address bits [19:15]
  - function from [14:12]
  - extended register from [11:8]
  - register from [7:2]
  - write flag and write data from the access
- R3: Byte enables depend on `s_req_size` and the low address bits:
  - size 2 (32-bit) gives 4'b1111.
  - size 1 (16-bit) gives 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1.
  - size 0 (8-bit) gives 4'b0001 shifted left by addr[1:0].
- R4: An access taken while `bme_en` is low gets a response with `s_rsp_err`=1 in the cycle after acceptance, and no descriptor is issued.
- R5: An access with `s_req_burst`=1 gets an error response and no descriptor.
- R6: An access outside [BASE_ADDR, HIGH_ADDR] gets an error response and no descriptor.
- R7: Any bus number the window can encode, including the highest, is issued unfiltered.
- R8: A write whose completion carries `cpl_ur`=1 sets `irq_ur` in its response cycle. The write itself responds with `s_rsp_err`=0.
- R9: If no completion arrives within `cpl_timeout` cycles of the descriptor handshake, the access responds in the following cycle. A timed-out write sets `irq_to`.
- R10: A read responds with `s_rsp_rdata`=`cpl_data` and `s_rsp_err`=`cpl_ur`. A timed-out read responds with `s_rsp_err`=1 and data 0xFFFF_FFFF. Reads never set either interrupt flag.
- R11: `irq_ur` and `irq_to` stay set until `irq_clr[0]` or `irq_clr[1]` respectively is pulsed high. A set in the same cycle as a clear wins.
- R12: Only one request is outstanding:
  - `s_req_ready` is low from acceptance until after the single-cycle `s_rsp_valid` pulse.
  - While `cfg_ready` is low, `cfg_valid` and every descriptor field hold.
- R13: After reset, `s_req_ready`=1, `cfg_valid`=0, `s_rsp_valid`=0, and both interrupt flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bme_en | input | 1 | Bus-master enable from the bridge control register |
| cpl_timeout | input | TO_W | Completion timeout in cycles |
| s_req_valid | input | 1 | Slave access request |
| s_req_ready | output | 1 | Access accepted this cycle when valid |
| s_req_write | input | 1 | 1 = write, 0 = read |
| s_req_addr | input | 32 | Byte address |
| s_req_size | input | 2 | 0 = byte, 1 = half-word, 2 = word |
| s_req_burst | input | 1 | Multi-beat transfer attempt |
| s_req_wdata | input | 32 | Write data |
| s_rsp_valid | output | 1 | One-cycle response strobe |
| s_rsp_err | output | 1 | Error response |
| s_rsp_rdata | output | 32 | Read data |
| cfg_valid | output | 1 | Descriptor valid |
| cfg_ready | input | 1 | Descriptor taken |
| cfg_write | output | 1 | Configuration write |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_ext_reg | output | 4 | Extended register number |
| cfg_reg | output | 6 | Register number |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cpl_valid | input | 1 | Completion for the outstanding request |
| cpl_ur | input | 1 | Completion reports unsupported request |
| cpl_data | input | 32 | Completion data |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 for irq_ur, bit 1 for irq_to |
| irq_ur | output | 1 | Sticky unsupported-request interrupt |
| irq_to | output | 1 | Sticky completion-timeout interrupt |

## Verification
The hardest path to reach is the exact timeout boundary: the machine must sit in ST_WAIT for precisely `cpl_timeout` cycles with no completion. The bench reaches it by taking the descriptor and then withholding `cpl_valid`, while counting edges from the handshake to the response. It repeats this with a second, shorter limit so that the count is shown to follow the input rather than a fixed value. Descriptor stability is reached by holding `cfg_ready` low for several cycles and checking both the fields and `s_req_ready` on each of them.

// File: rtl/ecam_pkg.sv
package ecam_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } ecam_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef struct packed {
        logic        write;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  func;
        logic [3:0]  ext_reg;
        logic [5:0]  reg_no;
        logic [3:0]  be;
        logic [31:0] wdata;
    } cfg_desc_t;

endpackage

// File: rtl/ecam_addr_decode.sv
module ecam_addr_decode
    import ecam_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
    parameter logic [31:0] HIGH_ADDR = 32'h40FF_FFFF,
    parameter int          BUS_W     = 4
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    input  logic        write,
    input  logic [31:0] wdata,
    output logic        hit,
    output cfg_desc_t   desc
);

    always_comb begin
        hit          = (addr >= BASE_ADDR) && (addr <= HIGH_ADDR);
        desc         = '0;
        desc.write   = write;
        desc.wdata   = wdata;
        desc.bus[BUS_W-1:0] = addr[20 +: BUS_W];
        desc.dev     = addr[19:15];
        desc.func    = addr[14:12];
        desc.ext_reg = addr[11:8];
        desc.reg_no  = addr[7:2];
        unique case (size)
            SZ_BYTE: desc.be = 4'b0001 << addr[1:0];
            SZ_HALF: desc.be = addr[1] ? 4'b1100 : 4'b0011;
            default: desc.be = 4'b1111;
        endcase
    end

endmodule

// File: rtl/ecam_cpl_timer.sv
module ecam_cpl_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);

    logic [TO_W-1:0] cnt_q;

    always_comb begin
        expired = run && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ecam_irq_flags.sv
module ecam_irq_flags #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set,
    input  logic [N_FLAGS-1:0] clr,
    output logic [N_FLAGS-1:0] flags
);

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ecam_cfg_xlate.sv
module ecam_cfg_xlate
    import ecam_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
    parameter logic [31:0] HIGH_ADDR = 32'h40FF_FFFF,
    parameter int          TO_W      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bme_en,
    input  logic [TO_W-1:0] cpl_timeout,
    input  logic            s_req_valid,
    output logic            s_req_ready,
    input  logic            s_req_write,
    input  logic [31:0]     s_req_addr,
    input  logic [1:0]      s_req_size,
    input  logic            s_req_burst,
    input  logic [31:0]     s_req_wdata,
    output logic            s_rsp_valid,
    output logic            s_rsp_err,
    output logic [31:0]     s_rsp_rdata,
    output logic            cfg_valid,
    input  logic            cfg_ready,
    output logic            cfg_write,
    output logic [7:0]      cfg_bus,
    output logic [4:0]      cfg_dev,
    output logic [2:0]      cfg_func,
    output logic [3:0]      cfg_ext_reg,
    output logic [5:0]      cfg_reg,
    output logic [3:0]      cfg_be,
    output logic [31:0]     cfg_wdata,
    input  logic            cpl_valid,
    input  logic            cpl_ur,
    input  logic [31:0]     cpl_data,
    input  logic [1:0]      irq_clr,
    output logic            irq_ur,
    output logic            irq_to
);

    localparam longint WIN_SIZE = longint'(HIGH_ADDR) - longint'(BASE_ADDR) + 1;
    localparam int     WIN_BITS = $clog2(WIN_SIZE);
    localparam int     BUS_W    = WIN_BITS - 20;

    ecam_state_e state_q, state_d;
    cfg_desc_t   dec_desc, desc_q;
    logic        dec_hit, accept, refuse;
    logic        rsp_err_q;
    logic [31:0] rsp_data_q;
    logic        to_start, to_run, to_expired;
    logic [1:0]  irq_set, irq_flags;

    ecam_addr_decode #(
        .BASE_ADDR (BASE_ADDR),
        .HIGH_ADDR (HIGH_ADDR),
        .BUS_W     (BUS_W)
    ) u_decode (
        .addr  (s_req_addr),
        .size  (s_req_size),
        .write (s_req_write),
        .wdata (s_req_wdata),
        .hit   (dec_hit),
        .desc  (dec_desc)
    );

    ecam_cpl_timer #(.TO_W(TO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (to_start),
        .run     (to_run),
        .limit   (cpl_timeout),
        .expired (to_expired)
    );

    ecam_irq_flags #(.N_FLAGS(2)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (irq_clr),
        .flags (irq_flags)
    );

    // Next-state logic
    always_comb begin
        accept  = s_req_valid && (state_q == ST_IDLE);
        refuse  = !bme_en || s_req_burst || !dec_hit;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = refuse ? ST_RESP : ST_ISSUE;
            ST_ISSUE: if (cfg_ready) state_d = ST_WAIT;
            ST_WAIT:  if (cpl_valid || to_expired) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            desc_q     <= '0;
            rsp_err_q  <= 1'b0;
            rsp_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                rsp_err_q  <= refuse;
                rsp_data_q <= '1;
                if (!refuse) desc_q <= dec_desc;
            end else if (state_q == ST_WAIT) begin
                if (cpl_valid) begin
                    rsp_err_q  <= !desc_q.write && cpl_ur;
                    rsp_data_q <= desc_q.write ? 32'h0 : cpl_data;
                end else if (to_expired) begin
                    rsp_err_q  <= !desc_q.write;
                    rsp_data_q <= '1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        s_req_ready = (state_q == ST_IDLE);
        cfg_valid   = (state_q == ST_ISSUE);
        s_rsp_valid = (state_q == ST_RESP);
        s_rsp_err   = rsp_err_q;
        s_rsp_rdata = rsp_data_q;
        cfg_write   = desc_q.write;
        cfg_bus     = desc_q.bus;
        cfg_dev     = desc_q.dev;
        cfg_func    = desc_q.func;
        cfg_ext_reg = desc_q.ext_reg;
        cfg_reg     = desc_q.reg_no;
        cfg_be      = desc_q.be;
        cfg_wdata   = desc_q.wdata;
        to_start    = (state_q == ST_ISSUE) && cfg_ready;
        to_run      = (state_q == ST_WAIT);
        irq_set[0]  = (state_q == ST_WAIT) && cpl_valid && cpl_ur && desc_q.write;
        irq_set[1]  = (state_q == ST_WAIT) && !cpl_valid && to_expired && desc_q.write;
        irq_ur      = irq_flags[0];
        irq_to      = irq_flags[1];
    end

endmodule

// File: rtl/ecam_cfg_xlate_chk.sv
module ecam_cfg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bme_en,
    input logic        s_req_valid,
    input logic        s_req_ready,
    input logic        s_req_burst,
    input logic        s_rsp_valid,
    input logic        s_rsp_err,
    input logic        cfg_valid,
    input logic        cfg_ready,
    input logic [7:0]  cfg_bus,
    input logic [4:0]  cfg_dev,
    input logic [2:0]  cfg_func,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic        cpl_valid,
    input logic        cpl_ur,
    input logic [1:0]  irq_clr,
    input logic        irq_ur,
    input logic        irq_to
);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_bus) && $stable(cfg_dev)
            && $stable(cfg_func) && $stable(cfg_be) && $stable(cfg_wdata));

    assert_single_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> !s_req_ready);

    assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |=> !s_rsp_valid && s_req_ready);

    assert_bme_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_valid && s_req_ready && !bme_en |=> s_rsp_valid && s_rsp_err && !cfg_valid);

    assert_burst_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_req_valid && s_req_ready && s_req_burst |=> s_rsp_valid && s_rsp_err && !cfg_valid);

    assert_ur_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ur) |-> $past(cpl_valid && cpl_ur));

    assert_ur_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ur && !irq_clr[0] |=> irq_ur);

    assert_to_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_to && !irq_clr[1] |=> irq_to);

endmodule

bind ecam_cfg_xlate ecam_cfg_xlate_chk u_chk (.*);

// File: tb/ecam_cfg_xlate_tb.sv
module ecam_cfg_xlate_tb;

    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int          TO_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bme_en = 1'b1;
    logic [TO_W-1:0] cpl_timeout = 16'd20;
    logic            s_req_valid = 1'b0;
    logic            s_req_ready;
    logic            s_req_write = 1'b0;
    logic [31:0]     s_req_addr = '0;
    logic [1:0]      s_req_size = 2'd2;
    logic            s_req_burst = 1'b0;
    logic [31:0]     s_req_wdata = '0;
    logic            s_rsp_valid, s_rsp_err;
    logic [31:0]     s_rsp_rdata;
    logic            cfg_valid;
    logic            cfg_ready = 1'b0;
    logic            cfg_write;
    logic [7:0]      cfg_bus;
    logic [4:0]      cfg_dev;
    logic [2:0]      cfg_func;
    logic [3:0]      cfg_ext_reg;
    logic [5:0]      cfg_reg;
    logic [3:0]      cfg_be;
    logic [31:0]     cfg_wdata;
    logic            cpl_valid = 1'b0;
    logic            cpl_ur = 1'b0;
    logic [31:0]     cpl_data = '0;
    logic [1:0]      irq_clr = 2'b00;
    logic            irq_ur, irq_to;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  c_bus;
    logic [4:0]  c_dev;
    logic [2:0]  c_func;
    logic [3:0]  c_ext;
    logic [5:0]  c_reg;
    logic [3:0]  c_be;
    logic        c_wr;
    logic [31:0] c_wdata;
    logic        r_err;
    logic [31:0] r_data;
    int          r_wait;

    always #2.5 clk = ~clk;

    ecam_cfg_xlate #(.BASE_ADDR(BASE), .HIGH_ADDR(32'h40FF_FFFF), .TO_W(TO_W)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int bus, input int dev, input int fn,
                                            input int ext, input int rg, input int lo);
        return BASE | (32'(bus) << 20) | (32'(dev) << 15) | (32'(fn) << 12)
                    | (32'(ext) << 8) | (32'(rg) << 2) | 32'(lo);
    endfunction

    // mode: 0 normal completion, 1 UR completion, 2 no completion
    task automatic run_cfg(input logic wr, input logic [31:0] addr, input logic [1:0] size,
                           input logic [31:0] wd, input int stall, input int mode,
                           input int dly, input logic [31:0] cdata);
        @(negedge clk);
        s_req_write = wr; s_req_addr = addr; s_req_size = size;
        s_req_wdata = wd; s_req_burst = 1'b0; s_req_valid = 1'b1;
        @(negedge clk);
        s_req_valid = 1'b0;
        chk("R2 descriptor issued", 32'(cfg_valid), 32'd1);
        c_bus = cfg_bus; c_dev = cfg_dev; c_func = cfg_func; c_ext = cfg_ext_reg;
        c_reg = cfg_reg; c_be = cfg_be; c_wr = cfg_write; c_wdata = cfg_wdata;
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk("R12 valid held", 32'(cfg_valid), 32'd1);
            chk("R12 ready low while outstanding", 32'(s_req_ready), 32'd0);
            chk("R12 fields held", {cfg_bus, cfg_dev, cfg_func, cfg_be, cfg_reg},
                {c_bus, c_dev, c_func, c_be, c_reg});
        end
        cfg_ready = 1'b1;
        @(negedge clk);
        cfg_ready = 1'b0;
        r_wait = 0;
        for (int i = 0; i < 1000; i++) begin
            if (mode != 2 && i == dly) begin
                cpl_valid = 1'b1; cpl_ur = (mode == 1); cpl_data = cdata;
            end
            @(negedge clk);
            cpl_valid = 1'b0; cpl_ur = 1'b0;
            r_wait++;
            if (s_rsp_valid) break;
        end
        r_err = s_rsp_err; r_data = s_rsp_rdata;
        @(negedge clk);
        chk("R12 ready after response", 32'(s_req_ready), 32'd1);
    endtask

    task automatic refuse_access(input string req, input logic [31:0] addr,
                                 input logic burst, input logic bme);
        @(negedge clk);
        bme_en = bme; s_req_addr = addr; s_req_burst = burst;
        s_req_write = 1'b0; s_req_size = 2'd2; s_req_valid = 1'b1;
        @(negedge clk);
        s_req_valid = 1'b0; s_req_burst = 1'b0;
        chk({req, " error response"}, {31'd0, s_rsp_valid & s_rsp_err}, 32'd1);
        chk({req, " no descriptor"}, 32'(cfg_valid), 32'd0);
        @(negedge clk);
        chk({req, " still no descriptor"}, 32'(cfg_valid), 32'd0);
        bme_en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R13 ready", 32'(s_req_ready), 32'd1);
        chk("R13 cfg_valid", 32'(cfg_valid), 32'd0);
        chk("R13 rsp_valid", 32'(s_rsp_valid), 32'd0);
        chk("R13 irqs", {30'd0, irq_ur, irq_to}, 32'd0);
    endtask

    task automatic t_read_word();
        run_cfg(1'b0, mk_addr(3, 17, 5, 10, 45, 0), 2'd2, 32'h0, 0, 0, 4, 32'hCAFE_F00D);
        chk("R2 bus", 32'(c_bus), 32'd3);
        chk("R2 dev", 32'(c_dev), 32'd17);
        chk("R2 func", 32'(c_func), 32'd5);
        chk("R2 ext reg", 32'(c_ext), 32'd10);
        chk("R2 reg", 32'(c_reg), 32'd45);
        chk("R2 read flag", 32'(c_wr), 32'd0);
        chk("R3 word be", 32'(c_be), 32'hF);
        chk("R10 read data", r_data, 32'hCAFE_F00D);
        chk("R10 read err", 32'(r_err), 32'd0);
        chk("R9 completion before limit", 32'(r_wait), 32'd5);
    endtask

    task automatic t_byte_enables();
        for (int lo = 0; lo < 4; lo++) begin
            run_cfg(1'b0, mk_addr(1, 2, 3, 4, 5, lo), 2'd0, 32'h0, 0, 0, 0, 32'h0);
            chk("R3 byte be", 32'(c_be), 32'(4'b0001 << lo));
        end
        run_cfg(1'b0, mk_addr(1, 2, 3, 4, 5, 0), 2'd1, 32'h0, 0, 0, 0, 32'h0);
        chk("R3 low half be", 32'(c_be), 32'h3);
        run_cfg(1'b0, mk_addr(1, 2, 3, 4, 5, 2), 2'd1, 32'h0, 0, 0, 0, 32'h0);
        chk("R3 high half be", 32'(c_be), 32'hC);
    endtask

    task automatic t_bus_max();
        run_cfg(1'b0, mk_addr(15, 31, 7, 15, 63, 0), 2'd2, 32'h0, 0, 0, 1, 32'h1234_5678);
        chk("R7 top bus issued", 32'(c_bus), 32'd15);
        chk("R1 bus field zero-extended", 32'(c_bus[7:4]), 32'd0);
        chk("R2 max dev", 32'(c_dev), 32'd31);
    endtask

    task automatic t_write_ur();
        run_cfg(1'b1, mk_addr(2, 0, 0, 0, 1, 0), 2'd2, 32'hA5A5_0001, 2, 1, 3, 32'h0);
        chk("R2 write data", c_wdata, 32'hA5A5_0001);
        chk("R2 write flag", 32'(c_wr), 32'd1);
        chk("R8 irq_ur set", 32'(irq_ur), 32'd1);
        chk("R8 irq_to clear", 32'(irq_to), 32'd0);
        chk("R8 write rsp no err", 32'(r_err), 32'd0);
    endtask

    task automatic t_clear();
        repeat (3) @(negedge clk);
        chk("R11 irq_ur sticky", 32'(irq_ur), 32'd1);
        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        chk("R11 irq_ur cleared", 32'(irq_ur), 32'd0);
    endtask

    task automatic t_write_timeout(input int limit);
        cpl_timeout = 16'(limit);
        run_cfg(1'b1, mk_addr(4, 1, 0, 0, 0, 0), 2'd2, 32'h0, 0, 2, 0, 32'h0);
        chk("R9 timeout cycles", 32'(r_wait), 32'(limit));
        chk("R9 irq_to set", 32'(irq_to), 32'd1);
        chk("R9 irq_ur untouched", 32'(irq_ur), 32'd0);
        irq_clr = 2'b10;
        @(negedge clk);
        irq_clr = 2'b00;
        chk("R11 irq_to cleared", 32'(irq_to), 32'd0);
        cpl_timeout = 16'd20;
    endtask

    task automatic t_read_errors();
        run_cfg(1'b0, mk_addr(5, 0, 0, 0, 0, 0), 2'd2, 32'h0, 0, 2, 0, 32'h0);
        chk("R10 read timeout err", 32'(r_err), 32'd1);
        chk("R10 read timeout data", r_data, 32'hFFFF_FFFF);
        chk("R10 read timeout no irq", {30'd0, irq_ur, irq_to}, 32'd0);
        run_cfg(1'b0, mk_addr(5, 0, 0, 0, 0, 0), 2'd2, 32'h0, 0, 1, 2, 32'h0);
        chk("R10 read UR err", 32'(r_err), 32'd1);
        chk("R10 read UR no irq", 32'(irq_ur), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_word();
        t_byte_enables();
        t_bus_max();
        t_write_ur();
        t_clear();
        t_write_timeout(20);
        t_write_timeout(5);
        t_read_errors();
        refuse_access("R4 bme low", mk_addr(1, 0, 0, 0, 0, 0), 1'b0, 1'b0);
        refuse_access("R5 burst", mk_addr(1, 0, 0, 0, 0, 0), 1'b1, 1'b1);
        refuse_access("R6 below window", 32'h3FFF_FFFC, 1'b0, 1'b1);
        refuse_access("R6 above window", 32'h4100_0000, 1'b0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule